// File: doc/BRIEF.md
# Write-Failure PUF Challenge Sequencer

This controller turns an ordinary single-port SRAM into a challenge-response source. A challenge names a list of cell addresses, a reliability mask over those positions, a background value k and a code that picks how long the wordline stays open during a deliberately weakened write. The sequencer first writes k into every listed cell with a full-length wordline pulse. It then writes the complement of k into every listed cell with the shortened pulse that the code selects. Finally it reads every listed cell back. A cell whose weakened write did not take still holds k, and that write failure is the response bit.

Pulse lengths are whole clock cycles. The full length and the tap table are parameters, with tap t lasting TAP_BASE + t*TAP_STEP cycles. Because the pulse length is part of the challenge, the same cells can give several different responses. Positions flagged unreliable in the mask are left out when the response is built. The surviving bits are packed from bit 0 upward and come with a count of how many are valid.

Top module: `wfpuf_seq`

## Requirements
- R1: After reset the block is idle: `resp_valid`, `sel_err`, `mem_en`, `mem_we` and `mem_wl` are 0, and `resp_count` is 0.
- R2: During the first phase, every listed cell, in list order, gets one write of `chal_k` with `mem_wl` held high for FULL_WL consecutive cycles.
- R3: During the second phase, every listed cell, in list order, gets one write of the complement of `chal_k` with `mem_wl` held high for TAP_BASE + sel*TAP_STEP consecutive cycles.
- R4: All first-phase writes come before any second-phase write, and all writes come before the reads. The reads visit the listed cells once each, in list order. One sequence makes exactly 2*N_CELLS write pulses and N_CELLS reads.
- R5: A response bit is 1 when the cell reads back equal to `chal_k`, which means the weakened write failed. It is 0 when the cell reads back the complement. Read data is taken one cycle after the read is issued.
- R6: Only positions i with `chal_mask[i]`=1 contribute. Their bits are packed in list order starting at bit 0, bits above the packed ones are 0, and `resp_count` equals the number of set mask bits.
- R7: A start with a select code of N_TAPS or more raises `sel_err` in the next cycle. It causes no memory access and no response.
- R8: `resp_valid` is high for exactly one cycle at the end of each sequence. `resp_bits` and `resp_count` are valid in that cycle.
- R9: A start that arrives while a sequence is running is ignored. The running sequence completes with the challenge captured at its own start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch a sequence with the current challenge (taken in idle only) |
| chal_addrs | input | N_CELLS*ADDR_W | Cell address list, entry i in bits [i*ADDR_W +: ADDR_W] |
| chal_mask | input | N_CELLS | 1 = position i is reliable and goes into the response |
| chal_k | input | 1 | Background value written at full duration |
| chal_sel | input | SEL_W | Weakened-pulse tap select code |
| mem_en | output | 1 | SRAM access enable |
| mem_we | output | 1 | SRAM write enable |
| mem_wl | output | 1 | Wordline-enable pulse |
| mem_addr | output | ADDR_W | SRAM address |
| mem_wdata | output | 1 | SRAM write data |
| mem_rdata | input | 1 | SRAM read data, one cycle after a read access |
| resp_bits | output | N_CELLS | Packed response |
| resp_count | output | CNT_W | Number of valid packed bits |
| resp_valid | output | 1 | One-cycle response strobe |
| sel_err | output | 1 | Rejected select code strobe |

## Verification
A rejected select code shows up on `sel_err` one cycle after the start edge, so the bench samples at the next falling edge and once more a cycle later. A run lasts 1 + N(FULL_WL+2) + N(d+2) + N + 1 cycles, where d is the tap length. Instead of a fixed wait, the bench polls `resp_valid` at falling edges under a limit, checks the response in that same cycle, and requires the strobe to be low in the cycle after it. Pulse widths, write order and read order come from an SRAM model that measures every wordline pulse at the clock edge and applies the write only when the pulse reaches the cell's own threshold.

// File: rtl/wfpuf_pkg.sv
package wfpuf_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_BG,
        PH_STRESS,
        PH_READ,
        PH_DONE
    } phase_e;

    typedef struct packed {
        logic en;
        logic we;
        logic wl;
        logic wdata;
    } mem_cmd_t;

    function automatic int unsigned tap_cycles(input int unsigned tap,
                                               input int unsigned base,
                                               input int unsigned step);
        return base + tap * step;
    endfunction

    function automatic logic is_write_phase(input phase_e ph);
        return (ph == PH_BG) || (ph == PH_STRESS);
    endfunction

endpackage

// File: rtl/wfpuf_pulse_gen.sv
module wfpuf_pulse_gen #(
    parameter int LEN_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             go,
    input  logic [LEN_W-1:0] len,
    output logic             wl,
    output logic             busy
);
    logic [LEN_W-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst) begin
            remain <= '0;
        end else if (go && remain == '0) begin
            remain <= len;
        end else if (remain != '0) begin
            remain <= remain - 1'b1;
        end
    end

    assign wl   = (remain != '0);
    assign busy = wl;

    // R2
    pulse_len_chk: assert property (@(posedge clk) disable iff (rst)
        go |-> (len != '0));

    // R3
    go_idle_chk: assert property (@(posedge clk) disable iff (rst)
        go |-> !wl);

endmodule

// File: rtl/wfpuf_packer.sv
module wfpuf_packer #(
    parameter int N_CELLS = 128,
    parameter int IDX_W   = 7,
    parameter int CNT_W   = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               clr,
    input  logic               cap_vld,
    input  logic [IDX_W-1:0]   cap_idx,
    input  logic               cap_bit,
    input  logic [N_CELLS-1:0] mask,
    output logic [N_CELLS-1:0] resp,
    output logic [CNT_W-1:0]   count
);
    logic keep;

    assign keep = cap_vld && mask[cap_idx];

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            resp  <= '0;
            count <= '0;
        end else if (keep) begin
            resp[count[IDX_W-1:0]] <= cap_bit;
            count                  <= count + 1'b1;
        end
    end

    // R6
    count_bound_chk: assert property (@(posedge clk) disable iff (rst)
        count <= CNT_W'(N_CELLS));

    // R6
    skip_masked_chk: assert property (@(posedge clk) disable iff (rst)
        (cap_vld && !mask[cap_idx] && !clr) |=> $stable(count));

endmodule

// File: rtl/wfpuf_ctrl.sv
module wfpuf_ctrl
    import wfpuf_pkg::*;
#(
    parameter int N_CELLS = 128,
    parameter int IDX_W   = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             sel_ok,
    input  logic             pg_busy,
    output phase_e           phase,
    output logic [IDX_W-1:0] cell_idx,
    output logic             load,
    output logic             pg_go,
    output logic             rd_en,
    output logic             cap_vld,
    output logic [IDX_W-1:0] cap_idx,
    output logic             sel_err,
    output logic             resp_valid
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(N_CELLS - 1);

    logic launched;
    logic rd_done;
    logic cell_fin;

    assign load       = (phase == PH_IDLE) && start && sel_ok;
    assign pg_go      = is_write_phase(phase) && !launched && !pg_busy;
    assign cell_fin   = is_write_phase(phase) && launched && !pg_busy;
    assign rd_en      = (phase == PH_READ) && !rd_done;
    assign resp_valid = (phase == PH_DONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= PH_IDLE;
            cell_idx <= '0;
            launched <= 1'b0;
            rd_done  <= 1'b0;
            cap_vld  <= 1'b0;
            cap_idx  <= '0;
            sel_err  <= 1'b0;
        end else begin
            sel_err <= (phase == PH_IDLE) && start && !sel_ok;
            cap_vld <= rd_en;
            cap_idx <= cell_idx;
            case (phase)
                PH_IDLE: begin
                    if (load) begin
                        phase    <= PH_BG;
                        cell_idx <= '0;
                        launched <= 1'b0;
                        rd_done  <= 1'b0;
                    end
                end
                PH_BG, PH_STRESS: begin
                    if (pg_go) begin
                        launched <= 1'b1;
                    end else if (cell_fin) begin
                        launched <= 1'b0;
                        if (cell_idx == LAST) begin
                            cell_idx <= '0;
                            phase    <= (phase == PH_BG) ? PH_STRESS : PH_READ;
                        end else begin
                            cell_idx <= cell_idx + 1'b1;
                        end
                    end
                end
                PH_READ: begin
                    if (rd_en) begin
                        if (cell_idx == LAST) rd_done <= 1'b1;
                        else                  cell_idx <= cell_idx + 1'b1;
                    end
                    if (cap_vld && cap_idx == LAST) phase <= PH_DONE;
                end
                PH_DONE: begin
                    phase   <= PH_IDLE;
                    rd_done <= 1'b0;
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    // R8
    done_once_chk: assert property (@(posedge clk) disable iff (rst)
        resp_valid |=> !resp_valid);

    // R7
    err_idle_chk: assert property (@(posedge clk) disable iff (rst)
        sel_err |-> (phase == PH_IDLE));

    // R4
    read_after_write_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_READ) |-> !pg_busy);

endmodule

// File: rtl/wfpuf_seq.sv
module wfpuf_seq
    import wfpuf_pkg::*;
#(
    parameter int N_CELLS  = 128,
    parameter int ADDR_W   = 10,
    parameter int N_TAPS   = 3,
    parameter int TAP_BASE = 2,
    parameter int TAP_STEP = 2,
    parameter int FULL_WL  = 10,
    parameter int LEN_W    = 6,
    localparam int SEL_W   = (N_TAPS > 1) ? $clog2(N_TAPS) : 1,
    localparam int IDX_W   = (N_CELLS > 1) ? $clog2(N_CELLS) : 1,
    localparam int CNT_W   = $clog2(N_CELLS + 1)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      start,
    input  logic [N_CELLS*ADDR_W-1:0] chal_addrs,
    input  logic [N_CELLS-1:0]        chal_mask,
    input  logic                      chal_k,
    input  logic [SEL_W-1:0]          chal_sel,
    output logic                      mem_en,
    output logic                      mem_we,
    output logic                      mem_wl,
    output logic [ADDR_W-1:0]         mem_addr,
    output logic                      mem_wdata,
    input  logic                      mem_rdata,
    output logic [N_CELLS-1:0]        resp_bits,
    output logic [CNT_W-1:0]          resp_count,
    output logic                      resp_valid,
    output logic                      sel_err
);
    localparam int TBL_N = 2 ** SEL_W;

    logic [ADDR_W-1:0]  addr_q [N_CELLS];
    logic [N_CELLS-1:0] mask_q;
    logic               k_q;
    logic [SEL_W-1:0]   sel_q;

    logic [LEN_W-1:0]   tap_tbl [TBL_N];
    logic [LEN_W-1:0]   pulse_len;
    logic               sel_ok;

    phase_e             phase;
    logic [IDX_W-1:0]   cell_idx;
    logic               load;
    logic               pg_go;
    logic               pg_wl;
    logic               pg_busy;
    logic               rd_en;
    logic               cap_vld;
    logic [IDX_W-1:0]   cap_idx;
    logic               cap_bit;
    mem_cmd_t           cmd;

    for (genvar t = 0; t < TBL_N; t++) begin : g_tap
        if (t < N_TAPS) begin : g_live
            assign tap_tbl[t] = LEN_W'(tap_cycles(t, TAP_BASE, TAP_STEP));
        end else begin : g_pad
            assign tap_tbl[t] = LEN_W'(1);
        end
    end

    assign sel_ok    = ({1'b0, chal_sel} < (SEL_W + 1)'(N_TAPS));
    assign pulse_len = (phase == PH_STRESS) ? tap_tbl[sel_q] : LEN_W'(FULL_WL);

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
            k_q    <= 1'b0;
            sel_q  <= '0;
            for (int i = 0; i < N_CELLS; i++) addr_q[i] <= '0;
        end else if (load) begin
            mask_q <= chal_mask;
            k_q    <= chal_k;
            sel_q  <= chal_sel;
            for (int i = 0; i < N_CELLS; i++) addr_q[i] <= chal_addrs[i*ADDR_W +: ADDR_W];
        end
    end

    wfpuf_ctrl #(
        .N_CELLS (N_CELLS),
        .IDX_W   (IDX_W)
    ) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .sel_ok     (sel_ok),
        .pg_busy    (pg_busy),
        .phase      (phase),
        .cell_idx   (cell_idx),
        .load       (load),
        .pg_go      (pg_go),
        .rd_en      (rd_en),
        .cap_vld    (cap_vld),
        .cap_idx    (cap_idx),
        .sel_err    (sel_err),
        .resp_valid (resp_valid)
    );

    wfpuf_pulse_gen #(
        .LEN_W (LEN_W)
    ) u_pulse (
        .clk  (clk),
        .rst  (rst),
        .go   (pg_go),
        .len  (pulse_len),
        .wl   (pg_wl),
        .busy (pg_busy)
    );

    assign cap_bit = (mem_rdata == k_q);

    wfpuf_packer #(
        .N_CELLS (N_CELLS),
        .IDX_W   (IDX_W),
        .CNT_W   (CNT_W)
    ) u_pack (
        .clk     (clk),
        .rst     (rst),
        .clr     (load),
        .cap_vld (cap_vld),
        .cap_idx (cap_idx),
        .cap_bit (cap_bit),
        .mask    (mask_q),
        .resp    (resp_bits),
        .count   (resp_count)
    );

    always_comb begin
        cmd.we    = pg_wl && is_write_phase(phase);
        cmd.en    = cmd.we || rd_en;
        cmd.wl    = cmd.en;
        cmd.wdata = (phase == PH_STRESS) ? ~k_q : k_q;
    end

    assign mem_en    = cmd.en;
    assign mem_we    = cmd.we;
    assign mem_wl    = cmd.wl;
    assign mem_wdata = cmd.wdata;
    assign mem_addr  = addr_q[cell_idx];

    // R2
    we_wl_chk: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (mem_wl && mem_en));

    // R9
    chal_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_BG || phase == PH_STRESS || phase == PH_READ)
        |=> ($stable(sel_q) && $stable(k_q) && $stable(mask_q)));

    // R2
    addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_we && $past(mem_we)) |-> $stable(mem_addr));

endmodule

// File: tb/wfpuf_seq_test.sv
module wfpuf_seq_test;
    localparam int N   = 8;
    localparam int AW  = 8;
    localparam int FWL = 8;

    typedef struct packed {
        logic [7:0] seed;
        logic [7:0] mask;
        logic       k;
        logic [1:0] sel;
    } vec_t;

    localparam vec_t VECS [5] = '{
        '{seed: 8'h03, mask: 8'hFF, k: 1'b0, sel: 2'd1},
        '{seed: 8'h50, mask: 8'hFF, k: 1'b1, sel: 2'd0},
        '{seed: 8'hA7, mask: 8'hB5, k: 1'b1, sel: 2'd2},
        '{seed: 8'h11, mask: 8'h00, k: 1'b0, sel: 2'd1},
        '{seed: 8'hC2, mask: 8'h80, k: 1'b1, sel: 2'd1}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [N*AW-1:0] chal_addrs = '0;
    logic [N-1:0]  chal_mask = '0;
    logic          chal_k = 1'b0;
    logic [1:0]    chal_sel = '0;
    logic          mem_en, mem_we, mem_wl, mem_wdata;
    logic [AW-1:0] mem_addr;
    logic          mem_rdata = 1'b0;
    logic [N-1:0]  resp_bits;
    logic [3:0]    resp_count;
    logic          resp_valid, sel_err;

    int total = 0;
    int bad   = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    wfpuf_seq #(
        .N_CELLS (N), .ADDR_W (AW), .N_TAPS (3), .TAP_BASE (1),
        .TAP_STEP (2), .FULL_WL (FWL), .LEN_W (4)
    ) uut (
        .clk (clk), .rst (rst), .start (start), .chal_addrs (chal_addrs),
        .chal_mask (chal_mask), .chal_k (chal_k), .chal_sel (chal_sel),
        .mem_en (mem_en), .mem_we (mem_we), .mem_wl (mem_wl),
        .mem_addr (mem_addr), .mem_wdata (mem_wdata), .mem_rdata (mem_rdata),
        .resp_bits (resp_bits), .resp_count (resp_count),
        .resp_valid (resp_valid), .sel_err (sel_err)
    );

    function automatic int thr(input int a);
        return 1 + ((a * 5 + 3) % 6);
    endfunction

    function automatic int dur(input int s);
        return 1 + 2 * s;
    endfunction

    // SRAM model: write lands only if the wordline pulse reaches the cell threshold
    logic          mem [256];
    logic          clr_log = 1'b0;
    int            run = 0;
    logic [AW-1:0] pa;
    logic          pd;
    int            pcnt = 0, rcnt = 0, acc = 0;
    logic [AW-1:0] plog_a [32];
    logic          plog_d [32];
    int            plog_w [32];
    logic [AW-1:0] rlog_a [32];

    initial for (int i = 0; i < 256; i++) mem[i] = 1'b0;

    always @(posedge clk) begin
        if (clr_log) begin
            pcnt <= 0; rcnt <= 0; acc <= 0;
        end else begin
            if (mem_en) acc <= acc + 1;
            if (mem_en && !mem_we) begin
                mem_rdata <= mem[mem_addr];
                if (rcnt < 32) rlog_a[rcnt] <= mem_addr;
                rcnt <= rcnt + 1;
            end
            if (mem_wl && mem_we) begin
                run <= run + 1; pa <= mem_addr; pd <= mem_wdata;
            end else if (run != 0) begin
                if (run >= thr(int'(pa))) mem[pa] <= pd;
                if (pcnt < 32) begin
                    plog_a[pcnt] <= pa; plog_d[pcnt] <= pd; plog_w[pcnt] <= run;
                end
                pcnt <= pcnt + 1;
                run  <= 0;
            end
        end
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            bad   = bad + 1;
            total = total + 1;
            $display("FAIL watchdog got=%0d exp=<150000", cycles);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] got,
                       input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s got=%0h exp=%0h", req, got, exp);
        end
    endtask

    function automatic logic [AW-1:0] addr_of(input logic [7:0] seed, input int i);
        return AW'((int'(seed) + i * 37) & 255);
    endfunction

    task automatic clear_log();
        @(negedge clk); clr_log = 1'b1;
        @(negedge clk); clr_log = 1'b0;
    endtask

    task automatic run_vec(input vec_t v, input bit inject);
        logic [N-1:0] exp_bits = '0;
        int           exp_cnt = 0;
        int           n = 0;
        bit           ok2 = 1, ok3 = 1, ok4 = 1;
        for (int i = 0; i < N; i++) begin
            if (v.mask[i]) begin
                exp_bits[exp_cnt] = (dur(int'(v.sel)) < thr(int'(addr_of(v.seed, i))));
                exp_cnt++;
            end
        end
        clear_log();
        for (int i = 0; i < N; i++) chal_addrs[i*AW +: AW] = addr_of(v.seed, i);
        chal_mask = v.mask; chal_k = v.k; chal_sel = v.sel; start = 1'b1;
        @(negedge clk); start = 1'b0;
        if (inject) begin
            repeat (20) @(negedge clk);
            for (int i = 0; i < N; i++) chal_addrs[i*AW +: AW] = AW'(i);
            chal_mask = ~v.mask; chal_k = ~v.k; chal_sel = 2'd0; start = 1'b1;
            @(negedge clk); start = 1'b0;
        end
        while (!resp_valid && n < 5000) begin @(negedge clk); n++; end
        chk(resp_valid, "R8 response strobe", 32'(resp_valid), 1);
        if (!resp_valid) return;
        chk(resp_bits == exp_bits, inject ? "R9 busy start ignored" : "R5 response bits",
            32'(resp_bits), 32'(exp_bits));
        chk(int'(resp_count) == exp_cnt, "R6 valid count", 32'(resp_count), 32'(exp_cnt));
        @(negedge clk);
        chk(!resp_valid, "R8 strobe one cycle", 32'(resp_valid), 0);
        for (int i = 0; i < N; i++) begin
            if (plog_a[i] != addr_of(v.seed, i) || plog_d[i] != v.k || plog_w[i] != FWL) ok2 = 0;
            if (plog_a[N+i] != addr_of(v.seed, i) || plog_d[N+i] == v.k
                || plog_w[N+i] != dur(int'(v.sel))) ok3 = 0;
            if (rlog_a[i] != addr_of(v.seed, i)) ok4 = 0;
        end
        chk(ok2, "R2 background pulses", 32'(plog_w[0]), FWL);
        chk(ok3, "R3 stressed pulses", 32'(plog_w[N]), 32'(dur(int'(v.sel))));
        chk(ok4 && pcnt == 2*N && rcnt == N, "R4 phase order and counts",
            32'(pcnt * 256 + rcnt), 32'(2*N*256 + N));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!resp_valid && !sel_err && !mem_en && !mem_we && !mem_wl && resp_count == 0,
            "R1 reset state", {27'b0, resp_valid, sel_err, mem_en, mem_we, mem_wl}, 0);
        rst = 1'b0;
        @(negedge clk);

        for (int v = 0; v < 5; v++) run_vec(VECS[v], 1'b0);

        // R7: code 3 is outside the three-tap table
        clear_log();
        chal_sel = 2'd3; start = 1'b1;
        @(negedge clk); start = 1'b0;
        chk(sel_err, "R7 error strobe", 32'(sel_err), 1);
        @(negedge clk);
        chk(!sel_err, "R7 error clears", 32'(sel_err), 0);
        begin
            bit saw_valid = 0;
            for (int i = 0; i < 30; i++) begin
                @(negedge clk);
                if (resp_valid) saw_valid = 1;
            end
            chk(acc == 0 && !saw_valid, "R7 no access no response",
                32'(acc), 0);
        end

        // R9: restart during background phase
        run_vec(VECS[2], 1'b1);

        // R8: idle after done, no spurious activity
        clear_log();
        begin
            bit saw_valid = 0;
            for (int i = 0; i < 20; i++) begin
                @(negedge clk);
                if (resp_valid) saw_valid = 1;
            end
            chk(acc == 0 && !saw_valid, "R8 quiet after sequence", 32'(acc), 0);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule